// File: doc/BRIEF.md
# Rolling-Shutter Two-Row Readout Sequencer

This block runs the rolling-shutter readout of a binary pixel matrix in which every column ends in two discriminators. Two rows are therefore addressed and converted together. A row-pair pointer steps through the matrix and wraps back to the first pair, so frames follow one another without a break. For every pair the block holds the row select for one slot of a configurable number of clock cycles. Inside that slot it drives the pixel signal-sample and reference-sample strobes, then the discriminator offset-compensation phase, then one idle cycle, then the latch strobe. At the last cycle of the slot it hands the two latched hit vectors, one per discriminator, to the zero-suppression stage with a one-cycle valid. A frame-start flag marks the pair at the top of the matrix.

The row count and the slot length are sampled when a run starts. At 125 MHz, a 25-cycle slot gives the 200 ns baseline pair time and a 13-cycle slot gives roughly the 100 ns fast pair time. A stop request is held until the frame in progress has finished, so the zero suppressor never receives a partial frame.

Top module: `rs_pair_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `row_sel`, all phase strobes, `out_valid`, `out_frame_start` and the hit outputs are 0, and `row_pair` is 0.
- R2: A `start` pulse while idle starts a run. From the next cycle, `busy` is 1 and slot cycle 0 of pair 0 is presented. The run uses the `cfg_rows` and `cfg_slot` values present at that start. Changes to `cfg_rows` or `cfg_slot`, and further `start` pulses, during a run have no effect on it.
- R3: Each slot lasts L cycles, where L equals `cfg_slot`, or 8 if `cfg_slot` is below 8. `row_sel` is 1 in every cycle of every slot of a run.
- R4: `smp_sig` is 1 only in slot cycle 1 and `smp_ref` only in slot cycle 2.
- R5: `dsc_comp` is 1 in slot cycles 3 through L-4. Slot cycle L-3 has no strobe. `dsc_latch` is 1 only in slot cycle L-2. At most one of the five strobes is ever high in a cycle.
- R6: `out_valid` is 1 only in slot cycle L-1. During that cycle `out_hits_top` and `out_hits_bot` equal the `hit_top` and `hit_bot` inputs sampled at the clock edge that ends slot cycle L-2.
- R7: Pair p addresses rows 2p and 2p+1. The number of pairs is floor(R/2), where R is `cfg_rows` clamped to MAX_ROWS, with a minimum of 1 pair. `row_pair` advances by one after each slot and wraps from the last pair to 0.
- R8: `out_frame_start` is 1 exactly when `out_valid` is 1 and `row_pair` is 0.
- R9: A `stop` pulse during a run takes effect after the final cycle of the last pair of the frame in progress. This includes a pulse given in that final cycle. `busy` then falls and `row_pair` returns to 0.
- R10: While idle, all strobes and `row_sel` stay 0. A `stop` pulse given while idle is discarded and does not end a later run early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| stop | input | 1 | Stop request, honoured at frame end |
| cfg_rows | input | ROW_W | Number of matrix rows |
| cfg_slot | input | SLOT_W | Slot length in clock cycles |
| hit_top | input | COLS | Discriminator outputs, first row of pair |
| hit_bot | input | COLS | Discriminator outputs, second row of pair |
| busy | output | 1 | A run is in progress |
| row_sel | output | 1 | Row-pair select enable |
| row_pair | output | PAIR_W | Current row-pair address |
| smp_sig | output | 1 | Pixel signal-sample strobe |
| smp_ref | output | 1 | Pixel reference/calibration-sample strobe |
| dsc_comp | output | 1 | Discriminator offset-compensation phase |
| dsc_latch | output | 1 | Discriminator latch strobe |
| out_valid | output | 1 | Hit data valid for the current pair |
| out_frame_start | output | 1 | Valid data belongs to pair 0 |
| out_hits_top | output | COLS | Latched hits, first row |
| out_hits_bot | output | COLS | Latched hits, second row |

## Verification
The assertions assume that `rst_n` is held low for several cycles at time zero. They also assume that `start` and `stop` are never raised in the same cycle from idle, because the phase ordering they check is only defined once a run has been accepted cleanly.

The stimulus drives all inputs on the falling edge. It raises `start` only as single-cycle pulses and raises `stop` only inside the last frame of a run, or alone while idle. It picks row counts and slot lengths at random, including values below the minimums and above MAX_ROWS, so that the clamping paths and the 8-cycle minimum slot are exercised as well.

// File: rtl/rs_seq_pkg.sv
// Shared constants and types of the row-pair readout sequencer.
// Assumes slot counters are at least 4 bits wide.
package rs_seq_pkg;
    // Shortest slot that still fits every phase plus the idle gap.
    localparam int MIN_SLOT = 8;

    // Strobes produced inside one slot, in their order of appearance.
    typedef struct packed {
        logic sig;
        logic refs;
        logic comp;
        logic latch;
        logic strobe;
    } phase_t;
endpackage

// File: rtl/rs_cfg_latch.sv
// Captures and clamps the run configuration when a run is accepted.
// Assumes MAX_ROWS is even and fits in ROW_W bits.
module rs_cfg_latch #(
    parameter int MAX_ROWS = 576,
    parameter int ROW_W    = 10,
    parameter int SLOT_W   = 8,
    parameter int PAIR_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ROW_W-1:0]  rows_in,
    input  logic [SLOT_W-1:0] slot_in,
    output logic [SLOT_W-1:0] slot_len,
    output logic [PAIR_W-1:0] last_pair
);
    import rs_seq_pkg::*;

    logic [ROW_W-1:0]  rows_cl;
    logic [ROW_W-1:0]  pairs_w;
    logic [ROW_W-1:0]  last_w;
    logic [SLOT_W-1:0] slot_cl;

    // Clamp the requested size and slot into the supported range.
    always_comb begin
        rows_cl = (rows_in > ROW_W'(MAX_ROWS)) ? ROW_W'(MAX_ROWS) : rows_in;
        pairs_w = rows_cl >> 1;
        last_w  = (pairs_w == '0) ? '0 : pairs_w - ROW_W'(1);
        slot_cl = (slot_in < SLOT_W'(MIN_SLOT)) ? SLOT_W'(MIN_SLOT) : slot_in;
    end

    // Hold the clamped values for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_len  <= SLOT_W'(MIN_SLOT);
            last_pair <= '0;
        end else if (take) begin
            slot_len  <= slot_cl;
            last_pair <= PAIR_W'(last_w);
        end
    end
endmodule

// File: rtl/rs_run_ctrl.sv
// Run/idle control: starts on an accepted start and stops only at a frame end.
// Assumes frame_end is high for exactly the final cycle of a frame.
module rs_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic stop,
    input  logic frame_end,
    output logic running
);
    logic stop_pend;

    // Running flag: set on start, cleared when a requested stop meets a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (start_acc)
            running <= 1'b1;
        else if (frame_end && (stop || stop_pend))
            running <= 1'b0;
    end

    // Pending stop: remembered while running, dropped while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !running)
            stop_pend <= 1'b0;
        else if (stop)
            stop_pend <= 1'b1;
    end
endmodule

// File: rtl/rs_slot_timer.sv
// Slot cycle counter and row-pair pointer of the rolling shutter.
// Assumes slot_len >= MIN_SLOT and last_pair stay stable during a run.
module rs_slot_timer #(
    parameter int SLOT_W = 8,
    parameter int PAIR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic [PAIR_W-1:0] last_pair,
    output logic [SLOT_W-1:0] cnt,
    output logic [PAIR_W-1:0] pair,
    output logic              frame_end
);
    logic slot_end;

    // Detect the last cycle of a slot and of a frame.
    always_comb begin
        slot_end  = running && (cnt == slot_len - SLOT_W'(1));
        frame_end = slot_end && (pair == last_pair);
    end

    // Cycle counter inside the slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !running || slot_end)
            cnt <= '0;
        else
            cnt <= cnt + SLOT_W'(1);
    end

    // Row-pair pointer, wrapping at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !running)
            pair <= '0;
        else if (slot_end)
            pair <= (pair == last_pair) ? '0 : pair + PAIR_W'(1);
    end
endmodule

// File: rtl/rs_phase_decode.sv
// Places the sampling and discrimination strobes at fixed slot offsets.
// Assumes slot_len >= MIN_SLOT so the compensation window is non-empty.
module rs_phase_decode #(
    parameter int SLOT_W = 8
) (
    input  logic                  running,
    input  logic [SLOT_W-1:0]     cnt,
    input  logic [SLOT_W-1:0]     slot_len,
    output rs_seq_pkg::phase_t    ph
);
    // Decode the slot cycle into one strobe at a time.
    always_comb begin
        ph.sig    = running && (cnt == SLOT_W'(1));
        ph.refs   = running && (cnt == SLOT_W'(2));
        ph.comp   = running && (cnt >= SLOT_W'(3)) && (cnt <= slot_len - SLOT_W'(4));
        ph.latch  = running && (cnt == slot_len - SLOT_W'(2));
        ph.strobe = running && (cnt == slot_len - SLOT_W'(1));
    end
endmodule

// File: rtl/rs_hit_capture.sv
// Registers both discriminator rows on the latch strobe.
// Assumes hit inputs are settled at the edge that ends the latch cycle.
module rs_hit_capture #(
    parameter int COLS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grab,
    input  logic [COLS-1:0] top_in,
    input  logic [COLS-1:0] bot_in,
    output logic [COLS-1:0] top_q,
    output logic [COLS-1:0] bot_q
);
    // Hold the latched two-row hit pattern until the next latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            bot_q <= '0;
        end else if (grab) begin
            top_q <= top_in;
            bot_q <= bot_in;
        end
    end
endmodule

// File: rtl/rs_pair_sequencer.sv
// Top of the two-row rolling-shutter readout sequencer.
// Assumes start and stop are synchronous single-cycle requests.
module rs_pair_sequencer #(
    parameter int MAX_ROWS = 576,
    parameter int COLS     = 16,
    parameter int SLOT_W   = 8,
    parameter int ROW_W    = $clog2(MAX_ROWS + 1),
    parameter int PAIR_W   = $clog2(MAX_ROWS / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [COLS-1:0]   hit_top,
    input  logic [COLS-1:0]   hit_bot,
    output logic              busy,
    output logic              row_sel,
    output logic [PAIR_W-1:0] row_pair,
    output logic              smp_sig,
    output logic              smp_ref,
    output logic              dsc_comp,
    output logic              dsc_latch,
    output logic              out_valid,
    output logic              out_frame_start,
    output logic [COLS-1:0]   out_hits_top,
    output logic [COLS-1:0]   out_hits_bot
);
    import rs_seq_pkg::*;

    logic              running;
    logic              start_acc;
    logic              frame_end;
    logic [SLOT_W-1:0] slot_len;
    logic [PAIR_W-1:0] last_pair;
    logic [SLOT_W-1:0] cnt;
    logic [PAIR_W-1:0] pair;
    phase_t            ph;

    // Only an idle sequencer accepts a start.
    assign start_acc = start && !running;

    rs_cfg_latch #(.MAX_ROWS(MAX_ROWS), .ROW_W(ROW_W), .SLOT_W(SLOT_W), .PAIR_W(PAIR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .take(start_acc), .rows_in(cfg_rows), .slot_in(cfg_slot),
        .slot_len(slot_len), .last_pair(last_pair)
    );

    rs_run_ctrl u_run (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .stop(stop),
        .frame_end(frame_end), .running(running)
    );

    rs_slot_timer #(.SLOT_W(SLOT_W), .PAIR_W(PAIR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .running(running), .slot_len(slot_len),
        .last_pair(last_pair), .cnt(cnt), .pair(pair), .frame_end(frame_end)
    );

    rs_phase_decode #(.SLOT_W(SLOT_W)) u_dec (
        .running(running), .cnt(cnt), .slot_len(slot_len), .ph(ph)
    );

    rs_hit_capture #(.COLS(COLS)) u_cap (
        .clk(clk), .rst_n(rst_n), .grab(ph.latch), .top_in(hit_top), .bot_in(hit_bot),
        .top_q(out_hits_top), .bot_q(out_hits_bot)
    );

    // Drive the control and hand-off outputs.
    always_comb begin
        busy            = running;
        row_sel         = running;
        row_pair        = pair;
        smp_sig         = ph.sig;
        smp_ref         = ph.refs;
        dsc_comp        = ph.comp;
        dsc_latch       = ph.latch;
        out_valid       = ph.strobe;
        out_frame_start = ph.strobe && (pair == '0);
    end
endmodule

// File: rtl/rs_seq_checker.sv
// Temporal checks on the sequencer ports; attached to the top by bind.
// Assumes rst_n is low for the first cycles of simulation.
module rs_seq_checker #(
    parameter int MAX_ROWS = 576,
    parameter int PAIR_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              row_sel,
    input logic [PAIR_W-1:0] row_pair,
    input logic              smp_sig,
    input logic              smp_ref,
    input logic              dsc_comp,
    input logic              dsc_latch,
    input logic              out_valid,
    input logic              out_frame_start
);
    localparam int MAX_PAIRS = MAX_ROWS / 2;

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_sig, smp_ref, dsc_comp, dsc_latch, out_valid})); // R5
    AST_COMP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_comp |=> !dsc_latch); // R5
    AST_SIG_THEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        smp_sig |=> smp_ref); // R4
    AST_LATCH_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_latch |=> out_valid); // R6
    AST_SELECT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_sig || smp_ref || dsc_comp || dsc_latch || out_valid) |-> row_sel); // R3
    AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_start |-> (out_valid && row_pair == '0)); // R8
    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(row_pair)) |-> $past(out_valid)); // R7
    AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_pair < PAIR_W'(MAX_PAIRS)); // R7
    AST_STOP_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(row_sel || smp_sig || smp_ref || dsc_comp || dsc_latch || out_valid)); // R10
endmodule

bind rs_pair_sequencer rs_seq_checker #(.MAX_ROWS(MAX_ROWS), .PAIR_W(PAIR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .row_sel(row_sel), .row_pair(row_pair),
    .smp_sig(smp_sig), .smp_ref(smp_ref), .dsc_comp(dsc_comp), .dsc_latch(dsc_latch),
    .out_valid(out_valid), .out_frame_start(out_frame_start)
);

// File: tb/tb_rs_pair_sequencer.sv
module tb_rs_pair_sequencer;
    localparam int MAX_ROWS = 576;
    localparam int COLS     = 16;
    localparam int SLOT_W   = 8;
    localparam int ROW_W    = $clog2(MAX_ROWS + 1);
    localparam int PAIR_W   = $clog2(MAX_ROWS / 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic [ROW_W-1:0]  cfg_rows = '0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [COLS-1:0]   hit_top = '0;
    logic [COLS-1:0]   hit_bot = '0;
    logic              busy, row_sel, smp_sig, smp_ref, dsc_comp, dsc_latch;
    logic              out_valid, out_frame_start;
    logic [PAIR_W-1:0] row_pair;
    logic [COLS-1:0]   out_hits_top, out_hits_bot;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    rs_pair_sequencer #(.MAX_ROWS(MAX_ROWS), .COLS(COLS), .SLOT_W(SLOT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_rows(cfg_rows),
        .cfg_slot(cfg_slot), .hit_top(hit_top), .hit_bot(hit_bot), .busy(busy),
        .row_sel(row_sel), .row_pair(row_pair), .smp_sig(smp_sig), .smp_ref(smp_ref),
        .dsc_comp(dsc_comp), .dsc_latch(dsc_latch), .out_valid(out_valid),
        .out_frame_start(out_frame_start), .out_hits_top(out_hits_top),
        .out_hits_bot(out_hits_bot)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_slot(input int s);
        return (s < 8) ? 8 : s;
    endfunction

    function automatic int eff_pairs(input int r);
        int rc;
        rc = (r > MAX_ROWS) ? MAX_ROWS : r;
        return (rc / 2 < 1) ? 1 : rc / 2;
    endfunction

    // Expected {sig, ref, comp, latch, valid} for slot cycle c of an L-cycle slot.
    function automatic logic [4:0] exp_phase(input int c, input int L);
        return {c == 1, c == 2, (c >= 3) && (c <= L - 4), c == L - 2, c == L - 1};
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " R9 busy low"}, 64'(busy), 0);
        chk({tag, " R10 strobes idle"},
            64'({row_sel, smp_sig, smp_ref, dsc_comp, dsc_latch, out_valid, out_frame_start}), 0);
        chk({tag, " R9 pair back to 0"}, 64'(row_pair), 0);
    endtask

    // One run: frames full frames, stop pulsed at cycle stop_cyc of the last frame.
    task automatic run(input int rows, input int slot, input int frames,
                       input int stop_cyc, input bit disturb);
        int L, P;
        logic [COLS-1:0] et, eb;
        logic [4:0] ep;
        L = eff_slot(slot);
        P = eff_pairs(rows);
        et = '0;
        eb = '0;
        cfg_rows = ROW_W'(rows);
        cfg_slot = SLOT_W'(slot);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int f = 0; f < frames; f++) begin
            for (int p = 0; p < P; p++) begin
                for (int c = 0; c < L; c++) begin
                    start = 1'b0;
                    // R2: a second start and new configuration mid-run must be ignored
                    if (disturb && f == 0 && p == 0 && c == 2) begin
                        start = 1'b1;
                        cfg_rows = ROW_W'($urandom_range(2, 40));
                        cfg_slot = SLOT_W'($urandom_range(8, 30));
                    end
                    stop = (f == frames - 1) && (p * L + c == stop_cyc);
                    ep = exp_phase(c, L);
                    chk("R2 R3 busy and row_sel", 64'({busy, row_sel}), 64'(2'b11));
                    chk("R4 sample strobes", 64'({smp_sig, smp_ref}), 64'(ep[4:3]));
                    chk("R5 comp/latch", 64'({dsc_comp, dsc_latch}), 64'(ep[2:1]));
                    chk("R6 valid", 64'(out_valid), 64'(ep[0]));
                    chk("R7 pair pointer", 64'(row_pair), 64'(p));
                    chk("R8 frame flag", 64'(out_frame_start), 64'(ep[0] && p == 0));
                    if (ep[0])
                        chk("R6 hit data", 64'({out_hits_top, out_hits_bot}), 64'({et, eb}));
                    hit_top = COLS'($urandom);
                    hit_bot = COLS'($urandom);
                    if (c == L - 2) begin
                        et = hit_top;
                        eb = hit_bot;
                    end
                    @(negedge clk);
                end
            end
        end
        stop = 1'b0;
        start = 1'b0;
        check_idle("end of run");
        repeat (2) @(negedge clk);
        check_idle("idle hold");
    endtask

    initial begin
        void'($urandom(32'h1C0FFEE));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs",
            64'({busy, row_sel, smp_sig, smp_ref, dsc_comp, dsc_latch, out_valid,
                 out_frame_start, out_hits_top, out_hits_bot}), 0);
        chk("R1 reset pair", 64'(row_pair), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("post reset R1");

        run(8, 10, 3, 17, 1'b0);              // R7 wrap over several frames
        run(2, 8, 4, 3, 1'b0);                // single pair, R8 every slot
        run(1, 3, 2, 0, 1'b0);                // R3 R7 clamps: 1 pair, 8-cycle slot
        run(7, 9, 2, 3 * 9 - 1, 1'b1);        // R9 stop in final cycle, R2 disturb
        // R10: stop while idle must be discarded
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check_idle("idle stop R10");
        run(6, 12, 2, 5, 1'b0);
        run(MAX_ROWS + 100, 8, 1, 0, 1'b0);   // R7 clamp to MAX_ROWS
        for (int i = 0; i < 6; i++) begin
            int r, s, fr, L, P;
            r  = $urandom_range(1, 40);
            s  = $urandom_range(0, 30);
            fr = $urandom_range(1, 3);
            L  = eff_slot(s);
            P  = eff_pairs(r);
            run(r, s, fr, $urandom_range(0, P * L - 1), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule